// File: doc/BRIEF.md
# Serial Port Baud Clock Generator

This block produces the bit-rate strobes for a serial port that can run either as an asynchronous UART or as a clock-synchronous shift link. It starts from the system clock and forms a base rate. The base rate is either every cycle or every other cycle. From the base rate it derives three prescaler taps. The chosen tap feeds a reload counter that divides it by the programmed value plus one. A final stage then shapes the result according to the mode. In asynchronous modes it divides by 16 to give the oversampled bit rate. In synchronous mode with the internal source, it halves the rate to make a shift clock and drives that clock onto a pin. In synchronous mode with the external source, it takes the shift clock from a pin through a synchronizer and turns the clock's edges into strobes.

All outputs are single-cycle enables in the system clock domain. No pulse-carrying interface here has a payload, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status level, and the enables are one-cycle strobes that cannot be stalled. The block also holds the two polarity inverters that sit in the serial data input and output paths.

Top module: `baud_clkgen`

## Requirements
- R1: After reset, `tx_en`, `rx_en` and `sclk_oe` are 0, and `sclk_out` equals the inverse of `clk_pol` (the shift clock idles high before the polarity inverter).
- R2: The base rate is one tick per cycle when `half_base`=0 and one tick every second cycle when `half_base`=1. `clk_sel` chooses the tap: 00 gives the base rate, 01 gives base/8, and 10 or 11 gives base/32, which is the base/8 tap divided by a further 4.
- R3: The divider gives one output per `reload`+1 ticks of the selected tap, where `reload` is the 8-bit reload value.
- R4: In the asynchronous modes (`mode` = 010, 100, 101 or 110), `tx_en` and `rx_en` pulse together once every 16 divider outputs.
- R5: In the synchronous mode (`mode` = 001) with `ext_clk`=0, the internal shift clock toggles on every divider output. `tx_en` pulses when the internal shift clock falls and `rx_en` pulses when it rises. `sclk_oe` is 1.
- R6: `sclk_out` is the internal shift clock XOR `clk_pol`. At a `tx_en` pulse in the internal synchronous mode, `sclk_out` equals `clk_pol`.
- R7: In the synchronous mode with `ext_clk`=1, `sclk_in` passes through a two-flop synchronizer and is XORed with `clk_pol`. A falling edge of that result gives one `tx_en` pulse and a rising edge gives one `rx_en` pulse, both within 4 cycles. `sclk_oe` is 0.
- R8: For `mode` = 000, 011 or 111, no `tx_en` or `rx_en` pulse is produced and `sclk_oe` is 0.
- R9: A change to `reload` takes effect only when the divider next reloads, so the divider period that is running completes at its old length.
- R10: `rxd_out` = `rxd_pin` XOR `rxd_inv`, and `txd_pin` = `txd_in` XOR `txd_inv`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_base | input | 1 | Use a half-rate base clock |
| clk_sel | input | 2 | Prescaler tap select |
| mode | input | 3 | Serial mode code |
| ext_clk | input | 1 | Shift clock source: 0 internal, 1 external pin |
| clk_pol | input | 1 | Shift clock polarity inversion |
| reload | input | 8 | Divider reload value n (divides by n+1) |
| sclk_in | input | 1 | External shift clock pin |
| rxd_pin | input | 1 | Serial data from the pin |
| rxd_inv | input | 1 | Invert received data |
| txd_in | input | 1 | Serial data from the transmitter |
| txd_inv | input | 1 | Invert transmitted data |
| tx_en | output | 1 | Transmit bit strobe |
| rx_en | output | 1 | Receive bit strobe |
| sclk_out | output | 1 | Shift clock to the pin |
| sclk_oe | output | 1 | Shift clock pin drive enable |
| rxd_out | output | 1 | Received data after the polarity inverter |
| txd_pin | output | 1 | Transmitted data after the polarity inverter |

## Verification
The asynchronous period is measured under four settings: the full-rate base with a small reload, the base/8 tap, the base/32 tap, and the half-rate base. Together they separate the effect of the tap choice, of the half-rate bit and of the reload+1 count. In synchronous internal mode, both the period and the spacing from `tx_en` to `rx_en` are measured, and the pin level at `tx_en` is checked under both polarities, which separates a falling-edge strobe from a rising-edge one. The external source is driven with single pin edges under both polarities, so that a swapped edge decoder shows up. A reload write in the middle of a period, followed by a measurement of the next two half-periods, tells a deferred update from an immediate one.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam logic [2:0] MODE_SYNC = 3'b001;

  function automatic logic mode_is_async(input logic [2:0] m);
    return (m == 3'b010) || (m == 3'b100) || (m == 3'b101) || (m == 3'b110);
  endfunction
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int PRE_A = 8,
  parameter int PRE_B = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_base,
  input  logic [1:0] clk_sel,
  output logic       tap_tick
);
  localparam int AW = $clog2(PRE_A);
  localparam int BW = $clog2(PRE_B);
  localparam logic [AW-1:0] A_LAST = AW'(PRE_A - 1);
  localparam logic [BW-1:0] B_LAST = BW'(PRE_B - 1);

  logic          half_q;
  logic [AW-1:0] cnt_a;
  logic [BW-1:0] cnt_b;
  logic          base_tick, tick_a, tick_b;

  assign base_tick = half_base ? half_q : 1'b1;
  assign tick_a    = base_tick && (cnt_a == A_LAST);
  assign tick_b    = tick_a && (cnt_b == B_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      cnt_a  <= '0;
      cnt_b  <= '0;
    end else begin
      half_q <= ~half_q;
      if (base_tick) cnt_a <= tick_a ? '0 : cnt_a + 1'b1;
      if (tick_a)    cnt_b <= tick_b ? '0 : cnt_b + 1'b1;
    end
  end

  always_comb begin
    unique case (clk_sel)
      2'b00:   tap_tick = base_tick;
      2'b01:   tap_tick = tick_a;
      default: tap_tick = tick_b;
    endcase
  end

  a_r2_tick8_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    tick_a |=> !tick_a);
  a_r2_tick32_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    tick_b |=> !tick_b);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tap_tick,
  input  logic [RW-1:0] reload,
  output logic          div_tick
);
  logic [RW-1:0] cnt;

  assign div_tick = en && tap_tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!en)      cnt <= '0;
    else if (tap_tick) cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end
endmodule

// File: rtl/baud_final.sv
module baud_final #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_tick,
  input  logic is_async,
  input  logic is_sync_int,
  input  logic is_sync_ext,
  input  logic clk_pol,
  input  logic sclk_in,
  output logic tx_en,
  output logic rx_en,
  output logic sclk_out,
  output logic sclk_oe
);
  localparam int OW = $clog2(OVS);
  localparam logic [OW-1:0] O_LAST = OW'(OVS - 1);

  logic [OW-1:0] ovs_cnt;
  logic          sclk_q;
  logic          sy1, sy2, sy3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= 1'b0;
      sy2 <= 1'b0;
      sy3 <= 1'b0;
    end else begin
      sy1 <= sclk_in;
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovs_cnt <= '0;
      sclk_q  <= 1'b1;
      tx_en   <= 1'b0;
      rx_en   <= 1'b0;
    end else begin
      tx_en <= 1'b0;
      rx_en <= 1'b0;
      if (is_async) begin
        sclk_q <= 1'b1;
        if (div_tick) begin
          ovs_cnt <= ovs_cnt + 1'b1;
          if (ovs_cnt == O_LAST) begin
            tx_en <= 1'b1;
            rx_en <= 1'b1;
          end
        end
      end else if (is_sync_int) begin
        ovs_cnt <= '0;
        if (div_tick) begin
          sclk_q <= ~sclk_q;
          if (sclk_q) tx_en <= 1'b1;
          else        rx_en <= 1'b1;
        end
      end else if (is_sync_ext) begin
        ovs_cnt <= '0;
        sclk_q  <= 1'b1;
        if (sy2 != sy3) begin
          if (sy2 ^ clk_pol) rx_en <= 1'b1;
          else               tx_en <= 1'b1;
        end
      end else begin
        ovs_cnt <= '0;
        sclk_q  <= 1'b1;
      end
    end
  end

  assign sclk_out = sclk_q ^ clk_pol;
  assign sclk_oe  = is_sync_int;

  // R4: asynchronous strobes always come as a pair
  a_r4_async_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_async) |-> (tx_en == rx_en));
  // R5: a transmit strobe in internal synchronous mode leaves the clock low
  a_r5_tx_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(is_sync_int) && tx_en) |-> !sclk_q);
  // R7: external edges give one strobe kind at a time
  a_r7_ext_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_sync_ext) |-> !(tx_en && rx_en));
  // R8: disabled modes stay silent
  a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_async && !is_sync_int && !is_sync_ext) |=> (!tx_en && !rx_en));
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
  import baud_pkg::*;
#(
  parameter int RW    = 8,
  parameter int PRE_A = 8,
  parameter int PRE_B = 4,
  parameter int OVS   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_base,
  input  logic [1:0]    clk_sel,
  input  logic [2:0]    mode,
  input  logic          ext_clk,
  input  logic          clk_pol,
  input  logic [RW-1:0] reload,
  input  logic          sclk_in,
  input  logic          rxd_pin,
  input  logic          rxd_inv,
  input  logic          txd_in,
  input  logic          txd_inv,
  output logic          tx_en,
  output logic          rx_en,
  output logic          sclk_out,
  output logic          sclk_oe,
  output logic          rxd_out,
  output logic          txd_pin
);
  logic is_async, is_sync_int, is_sync_ext;
  logic tap_tick, div_tick;

  assign is_async    = mode_is_async(mode);
  assign is_sync_int = (mode == MODE_SYNC) && !ext_clk;
  assign is_sync_ext = (mode == MODE_SYNC) && ext_clk;

  baud_prescale #(.PRE_A(PRE_A), .PRE_B(PRE_B)) u_pre (
    .clk(clk), .rst_n(rst_n), .half_base(half_base),
    .clk_sel(clk_sel), .tap_tick(tap_tick)
  );

  baud_divider #(.RW(RW)) u_div (
    .clk(clk), .rst_n(rst_n), .en(is_async || is_sync_int),
    .tap_tick(tap_tick), .reload(reload), .div_tick(div_tick)
  );

  baud_final #(.OVS(OVS)) u_fin (
    .clk(clk), .rst_n(rst_n), .div_tick(div_tick),
    .is_async(is_async), .is_sync_int(is_sync_int), .is_sync_ext(is_sync_ext),
    .clk_pol(clk_pol), .sclk_in(sclk_in),
    .tx_en(tx_en), .rx_en(rx_en), .sclk_out(sclk_out), .sclk_oe(sclk_oe)
  );

  assign rxd_out = rxd_pin ^ rxd_inv;
  assign txd_pin = txd_in ^ txd_inv;
endmodule

// File: tb/baud_clkgen_tb.sv
module baud_clkgen_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       half_base = 0;
  logic [1:0] clk_sel = 0;
  logic [2:0] mode = 3'b000;
  logic       ext_clk = 0, clk_pol = 0;
  logic [7:0] reload = 0;
  logic       sclk_in = 1, rxd_pin = 0, rxd_inv = 0, txd_in = 0, txd_inv = 0;
  logic       tx_en, rx_en, sclk_out, sclk_oe, rxd_out, txd_pin;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  baud_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .half_base(half_base), .clk_sel(clk_sel),
    .mode(mode), .ext_clk(ext_clk), .clk_pol(clk_pol), .reload(reload),
    .sclk_in(sclk_in), .rxd_pin(rxd_pin), .rxd_inv(rxd_inv),
    .txd_in(txd_in), .txd_inv(txd_inv), .tx_en(tx_en), .rx_en(rx_en),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .rxd_out(rxd_out), .txd_pin(txd_pin)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(input bit use_tx, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(use_tx ? tx_en : rx_en) && n < 5000);
  endtask

  task automatic period_of(input bit use_tx, output int p);
    int d;
    wait_pulse(use_tx, d);
    wait_pulse(use_tx, d);
    wait_pulse(use_tx, p);
  endtask

  task automatic count_win(input int cyc, output int ntx, output int nrx);
    ntx = 0; nrx = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      ntx += int'(tx_en);
      nrx += int'(rx_en);
    end
  endtask

  task automatic t_reset();
    chk("R1 tx_en", int'(tx_en), 0);
    chk("R1 rx_en", int'(rx_en), 0);
    chk("R1 sclk_oe", int'(sclk_oe), 0);
    chk("R1 sclk_out", int'(sclk_out), 1);
  endtask

  task automatic t_async();
    int p;
    mode = 3'b010; half_base = 0; clk_sel = 2'b00; reload = 8'd2;
    period_of(1, p); chk("R3 R4 base reload2", p, 48);
    mode = 3'b100; clk_sel = 2'b01; reload = 8'd0;
    period_of(0, p); chk("R2 R4 base/8", p, 128);
    mode = 3'b101; clk_sel = 2'b10;
    period_of(1, p); chk("R2 R4 base/32", p, 512);
    mode = 3'b110; half_base = 1; clk_sel = 2'b00; reload = 8'd1;
    period_of(1, p); chk("R2 R3 half base", p, 64);
    @(negedge clk); half_base = 0;
  endtask

  task automatic t_sync_int();
    int p, g;
    mode = 3'b001; ext_clk = 0; clk_pol = 0; clk_sel = 2'b00; reload = 8'd3;
    period_of(1, p); chk("R5 sync period", p, 8);
    wait_pulse(0, g); chk("R5 tx to rx", g, 4);
    chk("R5 sclk_oe", int'(sclk_oe), 1);
    wait_pulse(1, g); chk("R6 pin at tx pol0", int'(sclk_out), 0);
    clk_pol = 1;
    wait_pulse(1, g); chk("R6 pin at tx pol1", int'(sclk_out), 1);
    clk_pol = 0;
  endtask

  task automatic t_reload_change();
    int g;
    mode = 3'b001; ext_clk = 0; reload = 8'd9;
    wait_pulse(1, g); wait_pulse(1, g); wait_pulse(1, g);
    repeat (3) @(negedge clk);
    reload = 8'd1;
    wait_pulse(0, g); chk("R9 old period kept", g + 3, 10);
    wait_pulse(1, g); chk("R9 new period used", g, 2);
  endtask

  task automatic t_sync_ext();
    int ntx, nrx;
    mode = 3'b001; ext_clk = 1; clk_pol = 0; sclk_in = 1;
    repeat (8) @(negedge clk);
    chk("R7 sclk_oe", int'(sclk_oe), 0);
    sclk_in = 0; count_win(6, ntx, nrx);
    chk("R7 fall tx", ntx, 1); chk("R7 fall rx", nrx, 0);
    sclk_in = 1; count_win(6, ntx, nrx);
    chk("R7 rise rx", nrx, 1); chk("R7 rise tx", ntx, 0);
    clk_pol = 1; repeat (6) @(negedge clk);
    sclk_in = 0; count_win(6, ntx, nrx);
    chk("R7 pol fall rx", nrx, 1); chk("R7 pol fall tx", ntx, 0);
    clk_pol = 0; ext_clk = 0;
  endtask

  task automatic t_disabled();
    int ntx, nrx;
    clk_sel = 2'b00; reload = 8'd0;
    mode = 3'b011; count_win(200, ntx, nrx);
    chk("R8 mode011 pulses", ntx + nrx, 0);
    chk("R8 sclk_oe", int'(sclk_oe), 0);
    mode = 3'b111; count_win(200, ntx, nrx);
    chk("R8 mode111 pulses", ntx + nrx, 0);
    mode = 3'b000; count_win(200, ntx, nrx);
    chk("R8 mode000 pulses", ntx + nrx, 0);
  endtask

  task automatic t_data_inv();
    for (int k = 0; k < 4; k++) begin
      {rxd_pin, rxd_inv} = 2'(k); {txd_in, txd_inv} = 2'(k);
      #1;
      chk("R10 rxd", int'(rxd_out), int'(rxd_pin ^ rxd_inv));
      chk("R10 txd", int'(txd_pin), int'(txd_in ^ txd_inv));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_async();
    t_sync_int();
    t_reload_change();
    t_sync_ext();
    t_disabled();
    t_data_inv();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule